// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and an asynchronous parallel NOR flash device. The host asks for one whole flash operation in a single request. The sequencer turns that request into the flash's multi-cycle unlock and command protocol on the external bus: a fixed series of command writes, then any read cycles that follow. Words read back from the device return to the host one at a time, each marked by a single-cycle valid strobe.

Command addresses are written in word units. They are translated for the configured data width: in 16-bit mode they are shifted into the byte address space, and in 8-bit mode they pass through unchanged. User addresses (the program target and the sector address) are always driven exactly as given. Every bus access keeps chip enable and one strobe low for a fixed number of clock cycles, set by the parameter `WAIT_CYC`, and is followed by an idle cycle. A request that arrives while an operation is running is refused, and no bus cycles are produced for it.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `bus_ce_n`, `bus_we_n` and `bus_oe_n` are high, `busy` and `rd_valid` are low, and `req_ready` is high.
- R2: Read-ID, program, sector-erase and chip-erase operations begin with two writes: 0xAA to command address 0x555, then 0x55 to command address 0x2AA.
- R3: Op code 0 (read ID) follows the unlock pair with 0x90 at 0x555. It then reads command address 0x000 (manufacturer) and then 0x001 (device). Each word read is presented on `rd_data` with a one-cycle `rd_valid` pulse, in bus order.
- R4: Op code 2 (program) follows the unlock pair with 0xA0 at 0x555, then one write of `req_wdata` to `req_addr`, which is not translated.
- R5: Op code 3 (sector erase) issues the unlock pair, 0x80 at 0x555, a second unlock pair, and finally 0x30 at `req_addr`, which is not translated.
- R6: Op code 4 (chip erase) issues the same five leading writes as R5 and ends with 0x10 at 0x555.
- R7: Op code 1 (return to read) is a single write of 0xF0 at command address 0x000.
- R8: Op code 5 (query) writes 0x98 at command address 0x055, then reads command addresses 0x010, 0x011 and 0x012, each returned as in R3.
- R9: When `cfg_wide` is 1 at the moment a request is accepted, every command address of that operation appears on `bus_addr` shifted left by one bit. When it is 0, command addresses appear unchanged.
- R10: In each access, `bus_ce_n` and exactly one of `bus_we_n`/`bus_oe_n` stay low for exactly `WAIT_CYC` cycles, with address and write data stable. At least one idle cycle separates consecutive accesses.
- R11: A request made while `busy` is high raises `req_reject` for one cycle on the next cycle, adds no bus cycles, and leaves the running operation unchanged.
- R12: Op codes 6 and 7 are ignored: no bus cycle is issued and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device; sampled when a request is accepted |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0..5 valid) |
| req_addr | input | AW | Program target or sector address |
| req_wdata | input | DW | Program data word |
| req_ready | output | 1 | High when a request would be accepted |
| req_reject | output | 1 | One-cycle pulse: request refused because busy |
| busy | output | 1 | An operation is in progress |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a word read from the device |
| rd_data | output | DW | Word read from the device |
| bus_addr | output | AW | Flash address bus |
| bus_dout | output | DW | Flash write data |
| bus_din | input | DW | Flash read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Output enable, active low |

## Verification
All six operation codes are run in both width settings with two different user address/data pairs. The width sweep separates shifted command addresses from untranslated user addresses. The two pairs show that the target address and the program word are taken from the request and not from fixed constants. A device model returns a value computed from the address, so a read from the wrong location or a wrong word order shows up in the returned data. Separate cases send a second request in the middle of a program operation, and send the two unused op codes, to show that neither produces any bus traffic.

// File: rtl/nfc_pkg.sv
// Shared types for the NOR command sequencer.
// Assumes at most six bus accesses per operation.
package nfc_pkg;

    typedef enum logic [2:0] {
        OP_READ_ID  = 3'd0,
        OP_TO_READ  = 3'd1,
        OP_PROGRAM  = 3'd2,
        OP_SEC_ERS  = 3'd3,
        OP_CHIP_ERS = 3'd4,
        OP_QUERY    = 3'd5
    } op_e;

    localparam int STEP_W  = 3;
    localparam int CADR_W  = 12;

    // One bus access of an operation.
    typedef struct packed {
        logic              last;   // final access of the operation
        logic              rd;     // read access (else write)
        logic              tgt;    // use request address, untranslated
        logic              usr;    // drive request data word
        logic [CADR_W-1:0] cadr;   // command address, word units
        logic [7:0]        dat;    // command byte
    } step_t;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_ACT  = 2'd1,
        T_GAP  = 2'd2
    } tstate_e;

endpackage

// File: rtl/nfc_step_table.sv
// Decodes (operation, step index) into the description of one bus access.
// Pure combinational; assumes op is one of the six legal codes.
module nfc_step_table
    import nfc_pkg::*;
(
    input  op_e                op,
    input  logic [STEP_W-1:0]  idx,
    output step_t              step
);

    // Builds a step record from its fields.
    function automatic step_t mk(logic last, logic rd, logic tgt, logic usr,
                                 logic [CADR_W-1:0] a, logic [7:0] d);
        step_t s;
        s.last = last;
        s.rd   = rd;
        s.tgt  = tgt;
        s.usr  = usr;
        s.cadr = a;
        s.dat  = d;
        return s;
    endfunction

    logic needs_unlock;

    // Operations that open with the two-write unlock pair.
    always_comb begin
        needs_unlock = (op == OP_READ_ID) || (op == OP_PROGRAM) ||
                       (op == OP_SEC_ERS) || (op == OP_CHIP_ERS);
    end

    // Table lookup of the access for the current step.
    always_comb begin
        step = mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 8'h00);
        if (needs_unlock && idx == 3'd0) begin
            step = mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h555, 8'hAA);
        end else if (needs_unlock && idx == 3'd1) begin
            step = mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h2AA, 8'h55);
        end else begin
            case (op)
                OP_READ_ID: begin
                    case (idx)
                        3'd2:    step = mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h555, 8'h90);
                        3'd3:    step = mk(1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 8'h00);
                        default: step = mk(1'b1, 1'b1, 1'b0, 1'b0, 12'h001, 8'h00);
                    endcase
                end
                OP_TO_READ:
                    step = mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 8'hF0);
                OP_PROGRAM: begin
                    case (idx)
                        3'd2:    step = mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h555, 8'hA0);
                        default: step = mk(1'b1, 1'b0, 1'b1, 1'b1, 12'h000, 8'h00);
                    endcase
                end
                OP_SEC_ERS, OP_CHIP_ERS: begin
                    case (idx)
                        3'd2:    step = mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h555, 8'h80);
                        3'd3:    step = mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h555, 8'hAA);
                        3'd4:    step = mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h2AA, 8'h55);
                        default: step = (op == OP_SEC_ERS)
                                      ? mk(1'b1, 1'b0, 1'b1, 1'b0, 12'h000, 8'h30)
                                      : mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h555, 8'h10);
                    endcase
                end
                OP_QUERY: begin
                    case (idx)
                        3'd0:    step = mk(1'b0, 1'b0, 1'b0, 1'b0, 12'h055, 8'h98);
                        3'd1:    step = mk(1'b0, 1'b1, 1'b0, 1'b0, 12'h010, 8'h00);
                        3'd2:    step = mk(1'b0, 1'b1, 1'b0, 1'b0, 12'h011, 8'h00);
                        default: step = mk(1'b1, 1'b1, 1'b0, 1'b0, 12'h012, 8'h00);
                    endcase
                end
                default: step = mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 8'h00);
            endcase
        end
    end

endmodule

// File: rtl/nfc_addr_map.sv
// Forms the bus address and write data for one access.
// Command addresses are shifted one bit in 16-bit mode; request addresses
// pass untouched. Assumes AW > CADR_W.
module nfc_addr_map
    import nfc_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  step_t          step,
    input  logic           wide,
    input  logic [AW-1:0]  tgt_addr,
    input  logic [DW-1:0]  wdata,
    output logic [AW-1:0]  addr,
    output logic [DW-1:0]  dout
);

    localparam int SH_W = CADR_W + 1;

    logic [SH_W-1:0] cmd_byte;

    // Width translation of the command address.
    always_comb begin
        cmd_byte = wide ? {step.cadr, 1'b0} : {1'b0, step.cadr};
    end

    // Selects request or command address and data.
    always_comb begin
        addr = step.tgt ? tgt_addr : AW'(cmd_byte);
        dout = step.usr ? wdata : DW'(step.dat);
    end

endmodule

// File: rtl/nfc_access_timer.sv
// Times one bus access: WAIT_CYC active cycles, then one idle gap cycle.
// Strobes follow the current step's direction, which must stay constant
// while an access is active.
module nfc_access_timer
    import nfc_pkg::*;
#(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,        // start first access (from idle)
    input  logic more,      // another access follows this gap
    input  logic is_rd,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic gap_end,   // last cycle of the idle gap
    output logic cap_rd     // last active cycle of a read
);

    localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    tstate_e        st;
    logic [CW-1:0]  cnt;

    // Access state and active-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= T_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                T_IDLE: if (go) begin
                    st  <= T_ACT;
                    cnt <= '0;
                end
                T_ACT: begin
                    if (cnt == LAST) st <= T_GAP;
                    else             cnt <= cnt + 1'b1;
                end
                T_GAP: begin
                    cnt <= '0;
                    st  <= more ? T_ACT : T_IDLE;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    // Bus strobes and handshake to the sequencer.
    always_comb begin
        ce_n    = (st != T_ACT);
        we_n    = !((st == T_ACT) && !is_rd);
        oe_n    = !((st == T_ACT) && is_rd);
        gap_end = (st == T_GAP);
        cap_rd  = (st == T_ACT) && (cnt == LAST) && is_rd;
    end

    // R10: an access that has not reached its last cycle stays active.
    p_hold_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_ACT && cnt != LAST) |=> !ce_n);

    // R10: the cycle after an access ends is always idle.
    p_idle_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_ACT && cnt == LAST) |=> ce_n);

    // R10: never both strobes at once, and none without chip enable.
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !oe_n) |-> (!ce_n && (we_n != oe_n)));

endmodule

// File: rtl/nor_cmd_seq.sv
// Top of the NOR flash command sequencer. Accepts one operation request,
// steps through its bus accesses and returns read words. A request made
// while busy is refused. Assumes cfg_wide changes only between operations
// matter; it is latched at acceptance.
module nor_cmd_seq
    import nfc_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int WAIT_CYC = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wide,
    input  logic           req_valid,
    input  logic [2:0]     req_op,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ready,
    output logic           req_reject,
    output logic           busy,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_dout,
    input  logic [DW-1:0]  bus_din,
    output logic           bus_ce_n,
    output logic           bus_we_n,
    output logic           bus_oe_n
);

    logic               run;
    logic [STEP_W-1:0]  idx;
    op_e                op_q;
    logic [AW-1:0]      addr_q;
    logic [DW-1:0]      wdata_q;
    logic               wide_q;
    logic               op_legal;
    logic               accept;
    step_t              cur;
    logic               gap_end;
    logic               cap_rd;

    // Request qualification.
    always_comb begin
        op_legal  = (req_op <= 3'd5);
        accept    = req_valid && !run && op_legal;
        busy      = run;
        req_ready = !run;
    end

    // Operation registers, step index, reject and read-return pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run        <= 1'b0;
            idx        <= '0;
            op_q       <= OP_TO_READ;
            addr_q     <= '0;
            wdata_q    <= '0;
            wide_q     <= 1'b0;
            req_reject <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            req_reject <= req_valid && run;
            rd_valid   <= cap_rd;
            if (cap_rd) rd_data <= bus_din;
            if (accept) begin
                run     <= 1'b1;
                idx     <= '0;
                op_q    <= op_e'(req_op);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wide_q  <= cfg_wide;
            end else if (run && gap_end) begin
                if (cur.last) run <= 1'b0;
                else          idx <= idx + 1'b1;
            end
        end
    end

    nfc_step_table u_table (
        .op   (op_q),
        .idx  (idx),
        .step (cur)
    );

    nfc_addr_map #(.AW(AW), .DW(DW)) u_map (
        .step     (cur),
        .wide     (wide_q),
        .tgt_addr (addr_q),
        .wdata    (wdata_q),
        .addr     (bus_addr),
        .dout     (bus_dout)
    );

    nfc_access_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (accept),
        .more    (run && !cur.last),
        .is_rd   (cur.rd),
        .ce_n    (bus_ce_n),
        .we_n    (bus_we_n),
        .oe_n    (bus_oe_n),
        .gap_end (gap_end),
        .cap_rd  (cap_rd)
    );

    // R11: a refused request leaves the running operation untouched.
    p_reject_keeps_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && req_valid) |=> ($stable(op_q) && $stable(addr_q) && $stable(wdata_q)));

    // R12: no bus activity while no operation runs.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> bus_ce_n);

    // R3: returned words come only from a read access.
    p_rd_from_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!bus_oe_n));

    // R10: address and data hold across an access.
    p_bus_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ce_n && $past(!bus_ce_n)) |-> ($stable(bus_addr) && $stable(bus_dout)));

    // R9: width setting does not change inside an operation.
    p_wide_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(wide_q));

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int WT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wide = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, req_reject, busy, rd_valid;
    logic [DW-1:0] rd_data, bus_dout, bus_din;
    logic [AW-1:0] bus_addr;
    logic bus_ce_n, bus_we_n, bus_oe_n;

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .DW(DW), .WAIT_CYC(WT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_reject(req_reject),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n)
    );

    // Device model: read value is a function of the address.
    function automatic logic [DW-1:0] model(logic [AW-1:0] a);
        return DW'((a * 20'd7) ^ 20'h05A5A);
    endfunction
    assign bus_din = !bus_oe_n ? model(bus_addr) : '0;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    // Observed bus log.
    int            n_acc;
    int            a_kind [16];
    logic [AW-1:0] a_addr [16];
    logic [DW-1:0] a_data [16];
    int            a_len  [16];
    int            n_rd;
    logic [DW-1:0] r_data [16];
    int            n_rej;
    int            busy_seen;
    int            unstable;
    logic          prev_ce = 1'b1;

    // Expected log.
    int            e_n;
    int            e_kind [16];
    logic [AW-1:0] e_addr [16];
    logic [DW-1:0] e_data [16];

    task automatic clear_log();
        n_acc = 0; n_rd = 0; n_rej = 0; busy_seen = 0; unstable = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_seen++;
            if (req_reject) n_rej++;
            if (rd_valid && n_rd < 16) begin r_data[n_rd] = rd_data; n_rd++; end
            if (!bus_ce_n) begin
                if (prev_ce) begin
                    if (n_acc < 16) begin
                        a_kind[n_acc] = !bus_we_n ? 1 : (!bus_oe_n ? 2 : 0);
                        a_addr[n_acc] = bus_addr;
                        a_data[n_acc] = bus_dout;
                        a_len[n_acc]  = 1;
                    end
                    n_acc++;
                end else if (n_acc <= 16) begin
                    a_len[n_acc-1]++;
                    if (a_addr[n_acc-1] !== bus_addr || a_data[n_acc-1] !== bus_dout) unstable++;
                end
            end
            prev_ce = bus_ce_n;
        end
    end

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(int kind, logic [AW-1:0] a, logic [DW-1:0] d);
        e_kind[e_n] = kind; e_addr[e_n] = a; e_data[e_n] = d; e_n++;
    endtask

    // Builds the expected access list from the requirements.
    task automatic build(int op, bit wide, logic [AW-1:0] ta, logic [DW-1:0] td);
        logic [AW-1:0] c555, c2aa, c000, c001, c055, c010, c011, c012;
        int m;
        m = wide ? 2 : 1;
        c555 = AW'(12'h555 * m); c2aa = AW'(12'h2AA * m);
        c000 = '0;               c001 = AW'(1 * m);
        c055 = AW'(12'h055 * m); c010 = AW'(12'h010 * m);
        c011 = AW'(12'h011 * m); c012 = AW'(12'h012 * m);
        e_n = 0;
        if (op == 0 || op == 2 || op == 3 || op == 4) begin
            push(1, c555, 16'h00AA); push(1, c2aa, 16'h0055);
        end
        case (op)
            0: begin push(1, c555, 16'h0090); push(2, c000, 0); push(2, c001, 0); end
            1: push(1, c000, 16'h00F0);
            2: begin push(1, c555, 16'h00A0); push(1, ta, td); end
            3, 4: begin
                push(1, c555, 16'h0080); push(1, c555, 16'h00AA); push(1, c2aa, 16'h0055);
                if (op == 3) push(1, ta, 16'h0030); else push(1, c555, 16'h0010);
            end
            5: begin push(1, c055, 16'h0098); push(2, c010, 0); push(2, c011, 0); push(2, c012, 0); end
            default: ;
        endcase
    endtask

    function automatic string op_tag(int op);
        case (op)
            0: return "R3";
            1: return "R7";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic send(int op, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(int op, bit wide);
        string t;
        int ri;
        t = op_tag(op);
        check(n_acc == e_n, t, "access count", n_acc, e_n);
        check(unstable == 0, "R10", "bus change inside access", unstable, 0);
        ri = 0;
        for (int i = 0; i < e_n && i < n_acc; i++) begin
            string ti;
            ti = (i < 2 && op != 1 && op != 5) ? "R2" : t;
            if (wide) ti = {ti, "/R9"};
            check(a_kind[i] == e_kind[i], ti, $sformatf("kind #%0d", i), a_kind[i], e_kind[i]);
            check(a_addr[i] == e_addr[i], ti, $sformatf("addr #%0d", i), a_addr[i], e_addr[i]);
            if (e_kind[i] == 1)
                check(a_data[i] == e_data[i], ti, $sformatf("data #%0d", i), a_data[i], e_data[i]);
            check(a_len[i] == WT, "R10", $sformatf("active length #%0d", i), a_len[i], WT);
            if (e_kind[i] == 2) begin
                if (ri < n_rd)
                    check(r_data[ri] == model(e_addr[i]), t, $sformatf("read word %0d", ri),
                          r_data[ri], model(e_addr[i]));
                ri++;
            end
        end
        check(n_rd == ri, t, "read word count", n_rd, ri);
    endtask

    task automatic run_op(int op, bit wide, logic [AW-1:0] a, logic [DW-1:0] d);
        cfg_wide = wide;
        clear_log();
        build(op, wide, a, d);
        send(op, a, d);
        wait_idle();
        compare(op, wide);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        clear_log();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(bus_ce_n && bus_we_n && bus_oe_n, "R1", "strobes in reset", {bus_ce_n, bus_we_n, bus_oe_n}, 3'b111);
        check(!busy && !rd_valid && req_ready, "R1", "status in reset", {busy, rd_valid, req_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ce_n && bus_we_n && bus_oe_n && !busy && req_ready, "R1", "idle after reset",
              {bus_ce_n, bus_we_n, bus_oe_n, busy, req_ready}, 5'b11101);

        // Sweep of all operations, both widths, two request values.
        for (int w = 0; w < 2; w++)
            for (int op = 0; op < 6; op++)
                for (int v = 0; v < 2; v++)
                    run_op(op, w[0], v ? 20'h3A5C6 : 20'h00FF2, v ? 16'hBEEF : 16'h1357);

        // R11: second request during a program operation.
        cfg_wide = 1'b0;
        clear_log();
        build(2, 1'b0, 20'h01234, 16'hC0DE);
        send(2, 20'h01234, 16'hC0DE);
        repeat (3) @(negedge clk);
        send(4, 20'h0, 16'h0);
        wait_idle();
        check(n_rej == 1, "R11", "reject pulses", n_rej, 1);
        check(n_acc == e_n, "R11", "accesses with refused request", n_acc, e_n);
        compare(2, 1'b0);

        // R12: unused op codes.
        for (int op = 6; op < 8; op++) begin
            clear_log();
            send(op, 20'h00555, 16'h00AA);
            repeat (8) @(negedge clk);
            check(n_acc == 0, "R12", $sformatf("accesses for op %0d", op), n_acc, 0);
            check(busy_seen == 0, "R12", $sformatf("busy cycles for op %0d", op), busy_seen, 0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule